// File: doc/BRIEF.md
# Serial Clock-PLL Configuration Register

This block lets a host microcontroller program a clock PLL over three wires: a clear line, a shift clock and a data line. While the clear line is low, the host sends a fixed-length frame of 16 bits, one bit for each rising edge of the shift clock. On the falling edge of the sixteenth shift clock the frame is moved into a shadow register. That register drives the divider ratio, the operating-mode code, the phase-error polarity and the two test bits. When the host then raises the clear line, the block gives a one-cycle start strobe to the downstream counter.

All three pins are asynchronous to the block clock. They pass through a synchronizer before any edge is detected. A frame cut short by the clear line rising is dropped. Shift clocks that arrive while the clear line is high are ignored. Divider values below the legal floor are raised to that floor.

Top module: `pllcfg_serial_reg`

## Requirements
- R1: After reset: div_ratio = 384, mode_code = 2'b11, phase_pos = 1, test_bits = 2'b11, osc_halt = 0 and start_count = 0. Releasing reset with the clear line high produces no start strobe.
- R2: The first 10 frame bits form div_ratio, most significant bit first. The shadow outputs take the new frame 3 clock cycles after the falling edge of the 16th shift clock, sampled while clr_in is low.
- R3: Frame bits 11 and 12 become mode_code[1] and mode_code[0]. osc_halt is 1 exactly when mode_code is 2'b10.
- R4: Frame bit 13 becomes phase_pos (1 = positive sense). Bits 14 and 15 become test_bits[1] and test_bits[0]. Bit 16 is a pad bit with no effect.
- R5: No output changes before the 16th shift-clock falling edge. After 15 clocks the outputs still hold the previous frame.
- R6: A frame of fewer than 16 clocks ended by clr_in rising is discarded and the previous settings stay. The next full frame loads normally.
- R7: A received divider value below 5 is stored as 5. Values from 5 to 1023 are stored unchanged.
- R8: Shift clocks after the 16th in the same low period of clr_in leave all outputs unchanged.
- R9: Each low-to-high change of clr_in gives start_count high for exactly one cycle, 3 cycles after the pin change. A high-to-low change gives no strobe.
- R10: Shift clocks that arrive while clr_in is high load nothing and leave all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_in | input | 1 | Clear/enable pin; low while loading, rising edge starts counting |
| sclk_in | input | 1 | Serial shift clock pin |
| sdata_in | input | 1 | Serial data pin, sampled on shift-clock rise |
| div_ratio | output | 10 | Divider ratio for the program counter |
| mode_code | output | 2 | Operating-mode code |
| phase_pos | output | 1 | Phase-error sense, 1 = positive |
| test_bits | output | 2 | Test field |
| osc_halt | output | 1 | High when the mode code stops all oscillators |
| start_count | output | 1 | One-cycle strobe on clear-line rise |

## Verification
Each pin change goes through two synchronizer flops and one output register. A shadow update or a start strobe therefore appears in the third cycle after the pin edge. The bench drives pins on falling clock edges. It pushes the expected settings at the instant it drives the 16th falling shift edge, and the monitor compares them exactly three falling clock edges later, so both early and late updates are caught. For the frames that must change nothing, the bench pushes the unchanged settings at the same point, so the monitor checks the held values on the same schedule. The start strobe is checked in cycles 2, 3 and 4 after one clear-line rise, and the total number of strobes is counted over the whole run.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;
   localparam int MODE_W = 2;

   typedef enum logic [MODE_W-1:0] {
      MODE_LC_OSC   = 2'b00,
      MODE_PROG_CNT = 2'b01,
      MODE_HALT     = 2'b10,
      MODE_INT_VCO  = 2'b11
   } mode_e;

   localparam logic [MODE_W-1:0] MODE_RST = MODE_INT_VCO;

   // number of bits a frame layout consumes
   function automatic int used_bits(int div_w, int test_w);
      return div_w + MODE_W + 1 + test_w;
   endfunction
endpackage

// File: rtl/pllcfg_sync.sv
module pllcfg_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pllcfg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pllcfg_shifter.sv
module pllcfg_shifter #(
   parameter int FRAME_LEN = 16,
   parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_hi,
   input  logic                 sck,
   input  logic                 sdi,
   output logic [FRAME_LEN-1:0] word,
   output logic                 load_stb,
   output logic                 start_stb,
   output logic [CNT_W-1:0]     bit_cnt
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_LEN);

   logic sck_q, clr_q, done;
   logic sck_rise, sck_fall, clr_rise;

   assign sck_rise = sck & ~sck_q;
   assign sck_fall = ~sck & sck_q;
   assign clr_rise = clr_hi & ~clr_q;
   assign load_stb = sck_fall & ~clr_hi & (bit_cnt == FULL) & ~done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q     <= 1'b0;
         clr_q     <= 1'b1;
         done      <= 1'b0;
         bit_cnt   <= '0;
         word      <= '0;
         start_stb <= 1'b0;
      end else begin
         sck_q     <= sck;
         clr_q     <= clr_hi;
         start_stb <= clr_rise;
         if (clr_hi) begin
            bit_cnt <= '0;
            done    <= 1'b0;
         end else begin
            if (sck_rise && (bit_cnt < FULL)) begin
               word    <= {word[FRAME_LEN-2:0], sdi};
               bit_cnt <= bit_cnt + 1'b1;
            end
            if (load_stb) done <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/pllcfg_fields.sv
module pllcfg_fields
   import pllcfg_pkg::*;
#(
   parameter int               FRAME_LEN = 16,
   parameter int               DIV_W     = 10,
   parameter int               TEST_W    = 2,
   parameter int               MIN_DIV   = 5,
   parameter bit               CLAMP_EN  = 1'b1,
   parameter logic [DIV_W-1:0] DIV_RST   = 10'd384,
   parameter logic             POL_RST   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [FRAME_LEN-1:0] word,
   input  logic                 load_stb,
   output logic [DIV_W-1:0]     div_ratio,
   output logic [MODE_W-1:0]    mode_code,
   output logic                 phase_pos,
   output logic [TEST_W-1:0]    test_bits
);
   localparam int DIV_LSB  = FRAME_LEN - DIV_W;
   localparam int MODE_LSB = DIV_LSB - MODE_W;
   localparam int POL_BIT  = MODE_LSB - 1;
   localparam int TEST_LSB = POL_BIT - TEST_W;

   logic [DIV_W-1:0] div_raw, div_next;
   assign div_raw = word[FRAME_LEN-1 -: DIV_W];

   if (CLAMP_EN) begin : g_clamp
      assign div_next = (div_raw < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_raw;
   end else begin : g_pass
      assign div_next = div_raw;
   end

   if (TEST_LSB > 0) begin : g_pad
      logic pad_unused;
      assign pad_unused = ^word[TEST_LSB-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_ratio <= DIV_RST;
         mode_code <= MODE_RST;
         phase_pos <= POL_RST;
         test_bits <= '1;
      end else if (load_stb) begin
         div_ratio <= div_next;
         mode_code <= word[MODE_LSB +: MODE_W];
         phase_pos <= word[POL_BIT];
         test_bits <= word[TEST_LSB +: TEST_W];
      end
   end
endmodule

// File: rtl/pllcfg_serial_reg.sv
module pllcfg_serial_reg
   import pllcfg_pkg::*;
#(
   parameter int               FRAME_LEN   = 16,
   parameter int               DIV_W       = 10,
   parameter int               TEST_W      = 2,
   parameter int               MIN_DIV     = 5,
   parameter int               SYNC_STAGES = 2,
   parameter bit               CLAMP_EN    = 1'b1,
   parameter logic [DIV_W-1:0] DIV_RST     = 10'd384,
   parameter logic             POL_RST     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_in,
   input  logic              sclk_in,
   input  logic              sdata_in,
   output logic [DIV_W-1:0]  div_ratio,
   output logic [MODE_W-1:0] mode_code,
   output logic              phase_pos,
   output logic [TEST_W-1:0] test_bits,
   output logic              osc_halt,
   output logic              start_count
);
   localparam int CNT_W = $clog2(FRAME_LEN + 1);

   if (used_bits(DIV_W, TEST_W) > FRAME_LEN) begin : g_bad_layout
      $error("pllcfg_serial_reg: fields do not fit in the frame");
   end
   if (MIN_DIV < 1 || MIN_DIV >= (1 << DIV_W)) begin : g_bad_min
      $error("pllcfg_serial_reg: MIN_DIV out of range");
   end

   logic [2:0] pins_s;
   logic clr_s, sclk_s, sdata_s;
   logic [FRAME_LEN-1:0] word;
   logic load_stb;
   logic [CNT_W-1:0] bit_cnt;

   pllcfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({clr_in, sclk_in, sdata_in}), .q(pins_s)
   );
   assign {clr_s, sclk_s, sdata_s} = pins_s;

   pllcfg_shifter #(.FRAME_LEN(FRAME_LEN), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr_hi(clr_s), .sck(sclk_s), .sdi(sdata_s),
      .word(word), .load_stb(load_stb), .start_stb(start_count), .bit_cnt(bit_cnt)
   );

   pllcfg_fields #(
      .FRAME_LEN(FRAME_LEN), .DIV_W(DIV_W), .TEST_W(TEST_W), .MIN_DIV(MIN_DIV),
      .CLAMP_EN(CLAMP_EN), .DIV_RST(DIV_RST), .POL_RST(POL_RST)
   ) u_fields (
      .clk(clk), .rst_n(rst_n), .word(word), .load_stb(load_stb),
      .div_ratio(div_ratio), .mode_code(mode_code),
      .phase_pos(phase_pos), .test_bits(test_bits)
   );

   assign osc_halt = (mode_code == MODE_HALT);
endmodule

// File: rtl/pllcfg_serial_reg_chk.sv
module pllcfg_serial_reg_chk #(
   parameter int FRAME_LEN = 16,
   parameter int DIV_W     = 10,
   parameter int TEST_W    = 2,
   parameter int MIN_DIV   = 5,
   parameter bit CLAMP_EN  = 1'b1,
   parameter int CNT_W     = $clog2(FRAME_LEN + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr_s,
   input logic              load_stb,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic [DIV_W-1:0]  div_ratio,
   input logic [1:0]        mode_code,
   input logic              phase_pos,
   input logic [TEST_W-1:0] test_bits,
   input logic              start_count
);
   a_r5_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
      !load_stb |=> $stable({div_ratio, mode_code, phase_pos, test_bits}));

   a_r2_load_on_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |-> (bit_cnt == CNT_W'(FRAME_LEN)));

   a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_LEN));

   a_r10_count_cleared_high: assert property (@(posedge clk) disable iff (!rst_n)
      clr_s |=> (bit_cnt == '0));

   a_r9_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      start_count |=> !start_count);

   if (CLAMP_EN) begin : g_floor
      a_r7_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
         div_ratio >= DIV_W'(MIN_DIV));
   end
endmodule

bind pllcfg_serial_reg pllcfg_serial_reg_chk #(
   .FRAME_LEN(FRAME_LEN), .DIV_W(DIV_W), .TEST_W(TEST_W),
   .MIN_DIV(MIN_DIV), .CLAMP_EN(CLAMP_EN), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .clr_s(clr_s), .load_stb(load_stb),
   .bit_cnt(bit_cnt), .div_ratio(div_ratio), .mode_code(mode_code),
   .phase_pos(phase_pos), .test_bits(test_bits), .start_count(start_count)
);

// File: tb/pllcfg_serial_reg_test.sv
module pllcfg_serial_reg_test;
   timeunit 1ns; timeprecision 1ps;

   logic clk = 1'b0, rst_n = 1'b0;
   logic clr_pin = 1'b1, sclk_pin = 1'b0, sdata_pin = 1'b0;
   logic [9:0] div_ratio;
   logic [1:0] mode_code, test_bits;
   logic phase_pos, osc_halt, start_count;

   always #2.5 clk = ~clk;

   pllcfg_serial_reg uut (
      .clk(clk), .rst_n(rst_n), .clr_in(clr_pin), .sclk_in(sclk_pin),
      .sdata_in(sdata_pin), .div_ratio(div_ratio), .mode_code(mode_code),
      .phase_pos(phase_pos), .test_bits(test_bits), .osc_halt(osc_halt),
      .start_count(start_count)
   );

   typedef struct {
      logic [9:0] div;
      logic [1:0] mode;
      logic       pol;
      logic [1:0] test;
      string      req;
   } exp_t;

   exp_t q[$];
   exp_t cur;
   int n_run = 0, n_fail = 0;
   int starts = 0, starts_exp = 0;
   logic start_prev = 1'b0;
   bit finished = 1'b0;

   task automatic chk(string req, string what, int got, int exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [15:0] mk(int dv, logic [1:0] md, logic pl,
                                      logic [1:0] ts, logic pad);
      return {dv[9:0], md, pl, ts, pad};
   endfunction

   function automatic exp_t decode(logic [15:0] w, string req);
      exp_t e;
      e.div  = (w[15:6] < 10'd5) ? 10'd5 : w[15:6];
      e.mode = w[5:4];
      e.pol  = w[3];
      e.test = w[2:1];
      e.req  = req;
      return e;
   endfunction

   // drives bits first..last of w, pushing e right at the last falling edge
   task automatic send_bits(logic [15:0] w, int first, int last, bit push, exp_t e);
      for (int i = first; i <= last; i++) begin
         sdata_pin = w[15-i];
         tick(3);
         sclk_pin = 1'b1;
         tick(4);
         sclk_pin = 1'b0;
         if (push && i == last) q.push_back(e);
         tick(4);
      end
   endtask

   task automatic load_frame(logic [15:0] w, string req);
      clr_pin = 1'b0;
      tick(6);
      cur = decode(w, req);
      send_bits(w, 0, 15, 1'b1, cur);
      tick(6);
      clr_pin = 1'b1;
      starts_exp++;
      tick(8);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         wait (q.size() > 0);
         repeat (3) @(negedge clk);
         chk(q[0].req, "div_ratio", int'(div_ratio), int'(q[0].div));
         chk(q[0].req, "mode_code", int'(mode_code), int'(q[0].mode));
         chk(q[0].req, "phase_pos", int'(phase_pos), int'(q[0].pol));
         chk(q[0].req, "test_bits", int'(test_bits), int'(q[0].test));
         chk(q[0].req, "osc_halt", int'(osc_halt), int'(q[0].mode == 2'b10));
         void'(q.pop_front());
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (start_count) starts++;
         if (start_count && start_prev)
            chk("R9", "strobe width", 2, 1);
         start_prev = start_count;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      exp_t hold;
      tick(5);
      // R1 reset state
      chk("R1", "div_ratio", int'(div_ratio), 384);
      chk("R1", "mode_code", int'(mode_code), 3);
      chk("R1", "phase_pos", int'(phase_pos), 1);
      chk("R1", "test_bits", int'(test_bits), 3);
      chk("R1", "osc_halt", int'(osc_halt), 0);
      chk("R1", "start_count", int'(start_count), 0);
      rst_n = 1'b1;
      tick(6);
      chk("R1", "strobes after reset", starts, 0);

      load_frame(mk(683, 2'b01, 1'b0, 2'b11, 1'b0), "R2");
      load_frame(mk(300, 2'b10, 1'b1, 2'b10, 1'b1), "R3");
      load_frame(mk(1023, 2'b00, 1'b0, 2'b01, 1'b1), "R4");

      // R5 partial frame, then R8 surplus clocks
      clr_pin = 1'b0;
      tick(6);
      chk("R9", "strobes on clear fall", starts, starts_exp);
      hold = cur; hold.req = "R5";
      send_bits(mk(77, 2'b11, 1'b1, 2'b11, 1'b0), 0, 14, 1'b1, hold);
      tick(8);
      cur = decode(mk(77, 2'b11, 1'b1, 2'b11, 1'b0), "R5");
      send_bits(mk(77, 2'b11, 1'b1, 2'b11, 1'b0), 15, 15, 1'b1, cur);
      hold = cur; hold.req = "R8";
      send_bits(16'h2AA5, 0, 2, 1'b1, hold);
      tick(6);
      // R9 strobe timing
      clr_pin = 1'b1;
      starts_exp++;
      tick(2);
      chk("R9", "start cycle 2", int'(start_count), 0);
      tick(1);
      chk("R9", "start cycle 3", int'(start_count), 1);
      tick(1);
      chk("R9", "start cycle 4", int'(start_count), 0);
      tick(6);

      // R10 clocks with clear high
      hold = cur; hold.req = "R10";
      send_bits(mk(9, 2'b00, 1'b0, 2'b00, 1'b0), 0, 15, 1'b1, hold);
      tick(6);

      // R6 short frame discarded, next frame loads
      clr_pin = 1'b0;
      tick(6);
      send_bits(mk(600, 2'b10, 1'b0, 2'b00, 1'b0), 0, 6, 1'b0, cur);
      tick(6);
      clr_pin = 1'b1;
      starts_exp++;
      hold = cur; hold.req = "R6";
      q.push_back(hold);
      tick(10);
      load_frame(mk(512, 2'b01, 1'b1, 2'b11, 1'b0), "R6");

      // R7 floor
      load_frame(mk(0, 2'b11, 1'b1, 2'b11, 1'b0), "R7");
      load_frame(mk(4, 2'b01, 1'b0, 2'b11, 1'b0), "R7");
      load_frame(mk(5, 2'b00, 1'b1, 2'b11, 1'b0), "R7");
      load_frame(mk(6, 2'b11, 1'b0, 2'b11, 1'b1), "R7");

      wait (q.size() == 0);
      tick(6);
      chk("R9", "total strobes", starts, starts_exp);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule